// File: doc/BRIEF.md
# Decade Timebase Divider and Clock Selector

This block builds a sample clock for an acquisition system out of a bank of prescaler strobes. One prescaler strobe is picked by a 3-bit tap select. The picked strobe then runs through a cascade of decade counters. Each stage counts only the strobes it receives and passes one strobe on when it wraps from 9 to 0. The cascade output therefore gives the selected rate divided by 10, 100, 1000, 10000 and 100000.

A 4-bit time-per-division code addresses a one-of-sixteen selector over those five taps to form the internal clock. A separate modulo-100 counter divides the third stage's output by 100 to form a slow clock. A 2-bit source switch then chooses among three sources: the internal clock, the slow clock, and an external clock. The external clock is synchronized to the system clock and converted to a one-cycle enable on each of its rising edges.

All selections are re-timed so that a new choice only starts at a strobe of the newly chosen source. This keeps short gaps off the output. The result is a registered one-cycle clock enable plus a square wave that toggles on every enable.

Top module: `tbase_clk_sel`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, `clk_en_o` and `clk_sq_o` are 0, and the three selections are taken directly from their inputs. A selection present at reset therefore needs no alignment wait.
- R2: Each decade stage advances only when its input strobe is high and wraps from 9 to 0. Its output strobe is high in the cycle of the wrap. Each stage count stays in 0..9.
- R3: With source switch 0, time-per-division code k (k = 0..4) gives one `clk_en_o` pulse for every 10^(k+1) strobes of the selected prescaler tap. The first pulse comes at strobe number 10^(k+1) after reset.
- R4: Time-per-division codes 5..15 select a constant-low internal clock.
- R5: The slow clock divides the third decade stage's output by 100, giving one pulse per 100000 selected strobes.
- R6: The tap select picks bit `pre_sel_i` of `pre_stb_i` as the input of the decade cascade.
- R7: Source switch encoding: 0 = internal clock, 1 = slow clock, 2 = external clock, 3 = external clock. In positions 0 and 1 the external input has no effect.
- R8: The external input passes through a two-flop synchronizer. Each rising edge yields exactly one `clk_en_o` pulse, visible after the third rising system-clock edge that samples the new level.
- R9: A change of the time-per-division code, the tap select or the source switch takes effect at the next strobe of the newly requested source. That strobe itself is not forwarded. A change to a code in 5..15 takes effect on the next clock.
- R10: `clk_en_o` is registered and is never high in two consecutive cycles. `clk_sq_o` toggles exactly in the cycles where `clk_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_stb_i | input | NUM_PRE (8) | Prescaler strobes, one per tap |
| pre_sel_i | input | PRE_W (3) | Tap select feeding the decade cascade |
| tdiv_i | input | CODE_W (4) | Time-per-division code for the internal selector |
| mode_i | input | 2 | Source switch (internal, slow, external) |
| ext_clk_i | input | 1 | Asynchronous external clock |
| clk_en_o | output | 1 | One-cycle sample clock enable |
| clk_sq_o | output | 1 | Square wave toggling on each enable |

## Verification
A strobe on every cycle shows the plain decade ratios and the alignment of the first pulse. A strobe on every third cycle of another tap shows that stages count strobes rather than clock cycles and that the tap select is obeyed. Codes 1 to 3, the slow path, and the unused codes separate the tap wiring from the slow counter and from the constant-low entries. A toggling external clock, run under each switch position, shows edge counting, synchronizer latency, and that the external input is ignored in the internal positions. Mid-run code changes, to a slower tap and to a silent code and back, show the boundary-aligned switchover.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    SRC_INT     = 2'd0,
    SRC_SLOW    = 2'd1,
    SRC_EXT     = 2'd2,
    SRC_EXT_ALT = 2'd3
  } src_mode_e;

  localparam int SRC_W = 2;

endpackage

// File: rtl/tbase_mod_cnt.sv
module tbase_mod_cnt #(
  parameter int MOD = 10,
  localparam int W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  // Output strobe in the same cycle as the wrap.
  assign wrap_o = en_i && (cnt_o == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (en_i) begin
      if (cnt_o == LAST) cnt_o <= '0;
      else               cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/tbase_ext_sync.sv
module tbase_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tbase_sel_hold.sv
module tbase_sel_hold #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_i,
  input  logic         ready_i,
  output logic [W-1:0] act_o
);

  // Reset takes the request as is; afterwards a new request waits for ready_i.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_o <= req_i;
    end else if (ready_i && (req_i != act_o)) begin
      act_o <= req_i;
    end
  end

endmodule

// File: rtl/tbase_clk_sel.sv
module tbase_clk_sel
  import tbase_pkg::*;
#(
  parameter int NUM_PRE     = 8,
  parameter int NUM_DEC     = 5,
  parameter int DEC_MOD     = 10,
  parameter int SLOW_SRC    = 3,
  parameter int SLOW_MOD    = 100,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PRE_W = (NUM_PRE > 1) ? $clog2(NUM_PRE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PRE-1:0] pre_stb_i,
  input  logic [PRE_W-1:0]  pre_sel_i,
  input  logic [CODE_W-1:0] tdiv_i,
  input  logic [1:0]        mode_i,
  input  logic              ext_clk_i,
  output logic              clk_en_o,
  output logic              clk_sq_o
);

  localparam int DEC_W  = $clog2(DEC_MOD);
  localparam int SLOW_W = $clog2(SLOW_MOD);
  localparam logic [CODE_W-1:0] FIRST_QUIET = CODE_W'(NUM_DEC);

  function automatic logic pick_pre(input logic [NUM_PRE-1:0] v,
                                    input logic [PRE_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_PRE; i++) begin
      if (s == PRE_W'(i)) r = v[i];
    end
    return r;
  endfunction

  function automatic logic pick_tap(input logic [NUM_DEC-1:0] t,
                                    input logic [CODE_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (c == CODE_W'(i)) r = t[i];
    end
    return r;
  endfunction

  function automatic logic pick_src(input logic [1:0] m, input logic s_int,
                                    input logic s_slow, input logic s_ext);
    logic r;
    case (m)
      SRC_INT:  r = s_int;
      SRC_SLOW: r = s_slow;
      default:  r = s_ext;
    endcase
    return r;
  endfunction

  // Prescaler tap selection, aligned to the new tap's strobe
  logic [PRE_W-1:0] act_pre;
  logic             pre_cand;
  logic             chain_in;

  assign pre_cand = pick_pre(pre_stb_i, pre_sel_i);

  tbase_sel_hold #(.W(PRE_W)) u_pre_hold (
    .clk     (clk),
    .rst     (rst),
    .req_i   (pre_sel_i),
    .ready_i (pre_cand),
    .act_o   (act_pre)
  );

  assign chain_in = pick_pre(pre_stb_i, act_pre);

  // Decade cascade
  logic [NUM_DEC:0]         stage_en;
  logic [NUM_DEC*DEC_W-1:0] dec_cnt;
  logic [NUM_DEC-1:0]       tap;

  assign stage_en[0] = chain_in;

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    tbase_mod_cnt #(.MOD(DEC_MOD)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .en_i   (stage_en[g]),
      .cnt_o  (dec_cnt[g*DEC_W +: DEC_W]),
      .wrap_o (stage_en[g+1])
    );
  end

  assign tap = stage_en[NUM_DEC:1];

  // Slow clock from a chosen stage
  logic [SLOW_W-1:0] slow_cnt;
  logic              slow_stb;

  tbase_mod_cnt #(.MOD(SLOW_MOD)) u_slow (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tap[SLOW_SRC-1]),
    .cnt_o  (slow_cnt),
    .wrap_o (slow_stb)
  );

  // Internal selector
  logic [CODE_W-1:0] act_code;
  logic              code_quiet;
  logic              code_ready;
  logic              int_stb;

  assign code_quiet = (tdiv_i >= FIRST_QUIET);
  assign code_ready = pick_tap(tap, tdiv_i) | code_quiet;

  tbase_sel_hold #(.W(CODE_W)) u_code_hold (
    .clk     (clk),
    .rst     (rst),
    .req_i   (tdiv_i),
    .ready_i (code_ready),
    .act_o   (act_code)
  );

  assign int_stb = pick_tap(tap, act_code);

  // External clock
  logic ext_rise;

  tbase_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk     (clk),
    .rst     (rst),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  // Output source selector
  logic [1:0] act_mode;
  logic       mode_ready;
  logic       en_next;

  assign mode_ready = pick_src(mode_i, int_stb, slow_stb, ext_rise);

  tbase_sel_hold #(.W(SRC_W)) u_mode_hold (
    .clk     (clk),
    .rst     (rst),
    .req_i   (mode_i),
    .ready_i (mode_ready),
    .act_o   (act_mode)
  );

  assign en_next = pick_src(act_mode, int_stb, slow_stb, ext_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_o <= 1'b0;
      clk_sq_o <= 1'b0;
    end else begin
      clk_en_o <= en_next;
      clk_sq_o <= clk_sq_o ^ en_next;
    end
  end

endmodule

// File: rtl/tbase_clk_sel_chk.sv
module tbase_clk_sel_chk
  import tbase_pkg::*;
#(
  parameter int NUM_DEC  = 5,
  parameter int DEC_MOD  = 10,
  parameter int SLOW_MOD = 100,
  parameter int CODE_W   = 4,
  localparam int DEC_W  = $clog2(DEC_MOD),
  localparam int SLOW_W = $clog2(SLOW_MOD)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CODE_W-1:0]        tdiv_i,
  input logic                     clk_en_o,
  input logic                     clk_sq_o,
  input logic [CODE_W-1:0]        act_code,
  input logic [1:0]               act_mode,
  input logic                     ext_rise,
  input logic [NUM_DEC*DEC_W-1:0] dec_cnt,
  input logic [SLOW_W-1:0]        slow_cnt
);

  localparam logic [CODE_W-1:0] FIRST_QUIET = CODE_W'(NUM_DEC);

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_range
    assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
      dec_cnt[g*DEC_W +: DEC_W] < DEC_W'(DEC_MOD));
  end

  assert_slow_range_R5: assert property (@(posedge clk) disable iff (rst)
    slow_cnt < SLOW_W'(SLOW_MOD));

  assert_quiet_code_R4: assert property (@(posedge clk) disable iff (rst)
    (act_mode == SRC_INT && act_code >= FIRST_QUIET) |=> !clk_en_o);

  assert_ext_edge_only_R8: assert property (@(posedge clk) disable iff (rst)
    (act_mode[1] && !ext_rise) |=> !clk_en_o);

  assert_code_from_req_R9: assert property (@(posedge clk) disable iff (rst)
    (act_code != $past(act_code)) |-> (act_code == $past(tdiv_i)));

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |=> !clk_en_o);

  assert_sq_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |-> (clk_sq_o != $past(clk_sq_o)));

  assert_sq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !clk_en_o |-> $stable(clk_sq_o));

endmodule

bind tbase_clk_sel tbase_clk_sel_chk #(
  .NUM_DEC  (NUM_DEC),
  .DEC_MOD  (DEC_MOD),
  .SLOW_MOD (SLOW_MOD),
  .CODE_W   (CODE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tdiv_i   (tdiv_i),
  .clk_en_o (clk_en_o),
  .clk_sq_o (clk_sq_o),
  .act_code (act_code),
  .act_mode (act_mode),
  .ext_rise (ext_rise),
  .dec_cnt  (dec_cnt),
  .slow_cnt (slow_cnt)
);

// File: tb/tbase_clk_sel_tb.sv
module tbase_clk_sel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PRE    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pre_stb = '0;
  logic [2:0] pre_sel = '0;
  logic [3:0] tdiv = '0;
  logic [1:0] mode = '0;
  logic       ext = 1'b0;
  logic       en;
  logic       sq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_clk_sel u_dut (
    .clk       (clk),
    .rst       (rst),
    .pre_stb_i (pre_stb),
    .pre_sel_i (pre_sel),
    .tdiv_i    (tdiv),
    .mode_i    (mode),
    .ext_clk_i (ext),
    .clk_en_o  (en),
    .clk_sq_o  (sq)
  );

  int n_run = 0, n_fail = 0;
  int ph, sent, pulses, first_pos, misalign, align_mod;
  int sq_err, wide_err, ext_half, ext_rises, n_log;
  int pos_log [64];
  bit prev_en, exp_sq, quiet;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int count_in(input int lo, input int hi);
    int c = 0;
    for (int i = 0; i < n_log; i++)
      if (pos_log[i] >= lo && pos_log[i] <= hi) c++;
    return c;
  endfunction

  // One clock: sample what the last edge produced, then drive the next inputs.
  task automatic tick();
    @(posedge clk);
    #1;
    if (en) begin
      pulses++;
      if (first_pos < 0) first_pos = sent;
      if (align_mod > 0 && (sent % align_mod) != 0) misalign++;
      if (n_log < 64) begin pos_log[n_log] = sent; n_log++; end
    end
    if (en && prev_en) wide_err++;
    prev_en = en;
    exp_sq  = exp_sq ^ en;
    if (sq !== exp_sq) sq_err++;
    ph++;
    if (quiet) begin
      pre_stb = '0;
    end else begin
      for (int i = 0; i < NUM_PRE; i++) pre_stb[i] = ((ph % (i + 1)) == 0);
      if (pre_stb[pre_sel]) sent++;
      if (ext_half > 0) begin
        if (((ph / ext_half) % 2) == 1 && !ext) ext_rises++;
        ext = ((ph / ext_half) % 2) == 1;
      end
    end
  endtask

  task automatic do_reset(input int psel, input int code, input int m);
    rst = 1'b1; pre_stb = '0; ext = 1'b0; ext_half = 0; quiet = 1'b0;
    pre_sel = 3'(psel); tdiv = 4'(code); mode = 2'(m);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 enable low in reset", int'(en), 0);
    rst = 1'b0;
    ph = 0; sent = 0; pulses = 0; first_pos = -1; misalign = 0; align_mod = 0;
    sq_err = 0; wide_err = 0; ext_rises = 0; n_log = 0; prev_en = 0; exp_sq = 0;
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0);
    chk("R1 square low after reset", int'(sq), 0);
    tick();
    chk("R1 no pulse first cycle", int'(en), 0);
  endtask

  task automatic t_decade_basic();
    do_reset(0, 0, 0);
    align_mod = 10;
    repeat (101) tick();
    chk("R2 pulses per 100 strobes", pulses, 10);
    chk("R1/R3 first pulse at strobe 10", first_pos, 10);
    chk("R3 pulses on multiples of 10", misalign, 0);
    chk("R10 square toggles on enables", sq_err, 0);
    chk("R10 one-cycle enables", wide_err, 0);
    chk("R10 square parity", int'(sq), pulses % 2);
  endtask

  task automatic t_gappy();
    do_reset(2, 0, 0);
    align_mod = 10;
    repeat (300) tick();
    quiet = 1'b1;
    repeat (2) tick();
    chk("R6 tap2 strobes counted", sent, 100);
    chk("R2/R6 pulses from gappy tap", pulses, sent / 10);
    chk("R2 alignment on gappy tap", misalign, 0);
  endtask

  task automatic t_ladder();
    for (int code = 1; code <= 3; code++) begin
      do_reset(0, code, 0);
      align_mod = 10 ** (code + 1);
      repeat (2 * align_mod) tick();
      quiet = 1'b1;
      repeat (2) tick();
      chk($sformatf("R3 code %0d pulse count", code), pulses, 2);
      chk($sformatf("R3 code %0d first pulse", code), first_pos, align_mod);
      chk($sformatf("R3 code %0d alignment", code), misalign, 0);
    end
  endtask

  task automatic t_unused();
    do_reset(0, 5, 0);
    repeat (2000) tick();
    chk("R4 code 5 silent", pulses, 0);
    do_reset(0, 15, 0);
    repeat (2000) tick();
    chk("R4 code 15 silent", pulses, 0);
  endtask

  task automatic t_slow();
    do_reset(0, 0, 1);
    repeat (100000) tick();
    quiet = 1'b1;
    repeat (2) tick();
    chk("R5/R7 slow pulse count", pulses, 1);
    chk("R5 slow first pulse", first_pos, 100000);
  endtask

  task automatic t_ext();
    for (int m = 2; m <= 3; m++) begin
      do_reset(0, 9, m);
      ext_half = 4;
      repeat (200) tick();
      quiet = 1'b1;
      repeat (6) tick();
      chk($sformatf("R7/R8 mode %0d one pulse per edge", m), pulses, ext_rises);
      chk($sformatf("R8 mode %0d edges seen", m), int'(ext_rises > 20), 1);
      chk($sformatf("R8 mode %0d one-cycle pulses", m), wide_err, 0);
    end
    // latency of a single edge
    do_reset(0, 9, 2);
    quiet = 1'b1;
    tick();
    ext = 1'b1;
    tick(); chk("R8 no pulse after 1 edge", int'(en), 0);
    tick(); chk("R8 no pulse after 2 edges", int'(en), 0);
    tick(); chk("R8 pulse after 3 edges", int'(en), 1);
    tick(); chk("R8 pulse one cycle", int'(en), 0);
    // external ignored in internal position
    do_reset(0, 9, 0);
    ext_half = 4;
    repeat (200) tick();
    chk("R7 external ignored in internal mode", pulses, 0);
  endtask

  task automatic t_switch();
    do_reset(0, 0, 0);
    repeat (36) tick();
    tdiv = 4'd1;
    repeat (215) tick();
    chk("R9 old rate until new boundary", count_in(36, 100), 7);
    chk("R9 no pulse inside first new period", count_in(101, 199), 0);
    chk("R9 first new-rate pulse", count_in(200, 200), 1);

    do_reset(0, 0, 0);
    repeat (36) tick();
    tdiv = 4'd7;
    repeat (20) tick();
    chk("R9 silent code takes effect at once", count_in(36, 1000), 0);
    tdiv = 4'd0;
    repeat (35) tick();
    chk("R9 boundary strobe swallowed", count_in(56, 69), 0);
    chk("R9 first pulse after return", count_in(70, 70), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_decade_basic();
    t_gappy();
    t_ladder();
    t_unused();
    t_ext();
    t_switch();
    t_slow();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule